// File: doc/BRIEF.md
# Programmable Countdown Timer with Fractional Tick

This block is a down-counter that steps once per internal tick and produces an expiry pulse when its count runs out. It can run in a repeating mode, where the count is refilled from a separate limit register after every expiry, or in a single-run mode, where it halts after the first expiry. Software-side control arrives as single-cycle command strobes: start (with a mode select), stop, load the count, load the limit (optionally copying it into the count), and write the tick period. The live count and run state are always visible on the outputs.

The tick generator divides the system clock by a period made of an integer number of clocks plus a 32-bit binary fraction. The fraction is summed into an accumulator once per tick, and any tick interval in which that sum carries out is one clock longer. Over time the average tick interval therefore equals integer + fraction / 2^32 clocks. Zero periods and zero limits are guarded: the timer will not run on either.

Top module: `countdown_timer`

## Requirements
- R1: After reset the count, limit, period, fraction and expiry sticky flag are all zero, the run state is 0 (stopped) and the expiry pulse is low.
- R2: In repeating mode (run state 1) each tick lowers the count by one. A tick that finds the count at 1 (or 0) raises the expiry pulse, loads the count from the limit and stays in state 1.
- R3: In single-run mode (run state 2) a tick that finds the count at 1 (or 0) raises the expiry pulse, leaves the count at 0 and returns the run state to 0.
- R4: A start strobe while the run state is nonzero changes neither the state nor the count. A start while stopped with a zero integer period is refused, and the state stays 0.
- R5: An accepted start with a count of 0 raises the expiry pulse and loads the count from the limit in the same step. If the limit is also 0, the run state ends at 0.
- R6: A stop strobe while running returns the state to 0 and keeps the count at its value just before the stop. A stop while stopped changes nothing.
- R7: A count write loads the written value. While running it restarts the tick phase, so the next decrement comes one full period after the write. Writing 0 while running behaves as an expiry with refill from the limit.
- R8: A limit write always stores the value. With the reload flag set it also loads the count, restarts the tick phase if running, and stops the timer with an expiry pulse if the value is 0. Without the flag the count is left untouched.
- R9: With integer period P and fraction F, successive tick intervals are P clocks, plus one clock whenever the 32-bit fraction accumulator (cleared on every phase restart, then increased by F at each tick) carries out. P=2, F=0x80000000 gives intervals 2,3,2,3. The integer-only period write clears F to 0, while the full write sets both. Either write while running restarts the tick phase.
- R10: A period write with a zero integer part while running returns the run state to 0.
- R11: The expiry pulse is high for exactly one cycle per expiry event and sets a sticky flag. The clear strobe resets the flag, but an expiry in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| oneshot_i | input | 1 | Mode select with start: 1 single-run, 0 repeating |
| stop_i | input | 1 | Stop strobe |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CNT_W | Count write value |
| lim_wr_i | input | 1 | Limit write strobe |
| lim_reload_i | input | 1 | With limit write: also load the count |
| lim_wdata_i | input | CNT_W | Limit write value |
| per_int_wr_i | input | 1 | Integer-only period write (clears fraction) |
| per_full_wr_i | input | 1 | Integer and fraction period write |
| per_int_i | input | PER_W | Integer period in clocks |
| per_frac_i | input | 32 | Fractional period, units of 2^-32 clock |
| evt_clr_i | input | 1 | Clear strobe for the sticky expiry flag |
| count_o | output | CNT_W | Live count |
| state_o | output | 2 | Run state: 0 stopped, 1 repeating, 2 single-run |
| expire_o | output | 1 | Single-cycle expiry pulse |
| expire_sticky_o | output | 1 | Sticky expiry flag |

## Verification
The assertions take for granted that at most one command strobe (start, stop, count write, limit write, either period write) is high in any cycle. Their antecedents also single out cycles where only one strobe is active, so they stay exact even when the tick lands on the same cycle as a command. The random stimulus draws one command at a time and spaces each command with a cycle where every strobe is low. It keeps counts, limits and periods small so that expiries, zero values and phase restarts come up often. A cycle-level reference model in the bench, written in terms of clocks left in the current tick interval, is compared with the outputs every cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;

  parameter int unsigned TMR_FRAC_W = 32;

  typedef enum logic [1:0] {
    RUN_OFF  = 2'd0,
    RUN_LOOP = 2'd1,
    RUN_ONCE = 2'd2
  } run_e;

  // Carry out of the fractional accumulator when the fraction is added.
  function automatic logic frac_carry(input logic [TMR_FRAC_W-1:0] acc,
                                      input logic [TMR_FRAC_W-1:0] frac);
    logic [TMR_FRAC_W:0] sum;
    sum = {1'b0, acc} + {1'b0, frac};
    return sum[TMR_FRAC_W];
  endfunction

endpackage

// File: rtl/cdt_tick_gen.sv
module cdt_tick_gen
  import timer_pkg::*;
#(
  parameter int unsigned PER_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic                  restart_i,
  input  logic                  per_int_wr_i,
  input  logic                  per_full_wr_i,
  input  logic [PER_W-1:0]      per_int_i,
  input  logic [TMR_FRAC_W-1:0] per_frac_i,
  output logic [PER_W-1:0]      per_int_o,
  output logic                  tick_o
);

  localparam int unsigned TW = PER_W + 1;

  logic [PER_W-1:0]      per_int_q;
  logic [TMR_FRAC_W-1:0] per_frac_q;
  logic [PER_W-1:0]      ph_q;
  logic [TMR_FRAC_W-1:0] acc_q;
  logic                  stretch_w;
  logic [TW-1:0]         target_w;

  assign stretch_w = frac_carry(acc_q, per_frac_q);
  assign target_w  = {1'b0, per_int_q} - TW'(1) + TW'(stretch_w);
  assign tick_o    = run_i && ({1'b0, ph_q} >= target_w);
  assign per_int_o = per_int_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_int_q  <= '0;
      per_frac_q <= '0;
    end else if (per_int_wr_i || per_full_wr_i) begin
      per_int_q  <= per_int_i;
      per_frac_q <= per_full_wr_i ? per_frac_i : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i || restart_i) begin
      ph_q  <= '0;
      acc_q <= '0;
    end else if (tick_o) begin
      ph_q  <= '0;
      acc_q <= acc_q + per_frac_q;
    end else begin
      ph_q  <= ph_q + PER_W'(1);
    end
  end

  // The phase never runs past the longest allowed interval.
  assert_phase_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (ph_q <= per_int_q));

endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             oneshot_i,
  input  logic             stop_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             lim_wr_i,
  input  logic             lim_reload_i,
  input  logic [CNT_W-1:0] lim_wdata_i,
  input  logic             per_wr_i,
  input  logic [PER_W-1:0] per_int_new_i,
  input  logic [PER_W-1:0] per_int_q_i,
  input  logic             tick_i,
  input  logic             evt_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output run_e             st_o,
  output logic             restart_o,
  output logic             expire_o,
  output logic             sticky_o
);

  run_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic             evt_d, running_w, quiet_w;

  assign running_w = (st_q != RUN_OFF);
  assign quiet_w   = !(cnt_wr_i || lim_wr_i || per_wr_i);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    evt_d     = 1'b0;
    restart_o = 1'b0;
    lim_d     = lim_wr_i ? lim_wdata_i : lim_q;
    if (stop_i && running_w) begin
      st_d = RUN_OFF;
    end else if (start_i && !running_w) begin
      if (per_int_q_i != '0) begin
        st_d      = oneshot_i ? RUN_ONCE : RUN_LOOP;
        restart_o = 1'b1;
        if (cnt_q == '0) begin
          evt_d = 1'b1;
          cnt_d = lim_q;
          if (lim_q == '0) st_d = RUN_OFF;
        end
      end
    end else if (cnt_wr_i) begin
      cnt_d = cnt_wdata_i;
      if (running_w) begin
        restart_o = 1'b1;
        if (cnt_wdata_i == '0) begin
          evt_d = 1'b1;
          cnt_d = lim_q;
          if (lim_q == '0) st_d = RUN_OFF;
        end
      end
    end else if (lim_wr_i && lim_reload_i) begin
      cnt_d = lim_wdata_i;
      if (running_w) begin
        restart_o = 1'b1;
        if (lim_wdata_i == '0) begin
          evt_d = 1'b1;
          st_d  = RUN_OFF;
        end
      end
    end else if (per_wr_i && running_w) begin
      restart_o = 1'b1;
      if (per_int_new_i == '0) st_d = RUN_OFF;
    end else if (tick_i && running_w) begin
      if (cnt_q <= CNT_W'(1)) begin
        evt_d = 1'b1;
        if (st_q == RUN_ONCE || lim_q == '0) begin
          st_d  = RUN_OFF;
          cnt_d = '0;
        end else begin
          cnt_d = lim_q;
        end
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= RUN_OFF;
      cnt_q    <= '0;
      lim_q    <= '0;
      expire_o <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      lim_q    <= lim_d;
      expire_o <= evt_d;
      sticky_o <= evt_d ? 1'b1 : (evt_clr_i ? 1'b0 : sticky_o);
    end
  end

  assign cnt_o = cnt_q;
  assign st_o  = st_q;

  assert_loop_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && st_q == RUN_LOOP && cnt_q > CNT_W'(1) && quiet_w && !start_i && !stop_i)
    |=> (cnt_q == $past(cnt_q) - CNT_W'(1)) && (st_q == RUN_LOOP));

  assert_once_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && st_q == RUN_ONCE && cnt_q <= CNT_W'(1) && quiet_w && !start_i && !stop_i)
    |=> (st_q == RUN_OFF) && (cnt_q == '0) && expire_o);

  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && running_w && !stop_i && quiet_w && !tick_i)
    |=> $stable(st_q) && $stable(cnt_q));

  assert_stop_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && running_w) |=> (st_q == RUN_OFF) && $stable(cnt_q));

  assert_zero_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr_i && per_int_new_i == '0 && running_w && !start_i && !stop_i &&
     !cnt_wr_i && !lim_wr_i) |=> (st_q == RUN_OFF));

  assert_sticky_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> sticky_o);

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned PER_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  oneshot_i,
  input  logic                  stop_i,
  input  logic                  cnt_wr_i,
  input  logic [CNT_W-1:0]      cnt_wdata_i,
  input  logic                  lim_wr_i,
  input  logic                  lim_reload_i,
  input  logic [CNT_W-1:0]      lim_wdata_i,
  input  logic                  per_int_wr_i,
  input  logic                  per_full_wr_i,
  input  logic [PER_W-1:0]      per_int_i,
  input  logic [TMR_FRAC_W-1:0] per_frac_i,
  input  logic                  evt_clr_i,
  output logic [CNT_W-1:0]      count_o,
  output logic [1:0]            state_o,
  output logic                  expire_o,
  output logic                  expire_sticky_o
);

  logic             tick_w;
  logic             restart_w;
  logic             per_wr_w;
  logic [PER_W-1:0] per_int_w;
  run_e             st_w;

  assign per_wr_w = per_int_wr_i || per_full_wr_i;
  assign state_o  = st_w;

  cdt_tick_gen #(.PER_W(PER_W)) u_tick (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (st_w != RUN_OFF),
    .restart_i    (restart_w),
    .per_int_wr_i (per_int_wr_i),
    .per_full_wr_i(per_full_wr_i),
    .per_int_i    (per_int_i),
    .per_frac_i   (per_frac_i),
    .per_int_o    (per_int_w),
    .tick_o       (tick_w)
  );

  cdt_ctrl #(.CNT_W(CNT_W), .PER_W(PER_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .oneshot_i    (oneshot_i),
    .stop_i       (stop_i),
    .cnt_wr_i     (cnt_wr_i),
    .cnt_wdata_i  (cnt_wdata_i),
    .lim_wr_i     (lim_wr_i),
    .lim_reload_i (lim_reload_i),
    .lim_wdata_i  (lim_wdata_i),
    .per_wr_i     (per_wr_w),
    .per_int_new_i(per_int_i),
    .per_int_q_i  (per_int_w),
    .tick_i       (tick_w),
    .evt_clr_i    (evt_clr_i),
    .cnt_o        (count_o),
    .st_o         (st_w),
    .restart_o    (restart_w),
    .expire_o     (expire_o),
    .sticky_o     (expire_sticky_o)
  );

endmodule

// File: tb/countdown_timer_bench.sv
module countdown_timer_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        start_i, oneshot_i, stop_i, cnt_wr_i, lim_wr_i, lim_reload_i;
  logic        per_int_wr_i, per_full_wr_i, evt_clr_i;
  logic [63:0] cnt_wdata_i, lim_wdata_i;
  logic [31:0] per_int_i, per_frac_i;
  logic [63:0] count_o;
  logic [1:0]  state_o;
  logic        expire_o, expire_sticky_o;

  countdown_timer u_countdown_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .oneshot_i(oneshot_i),
    .stop_i(stop_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .lim_wr_i(lim_wr_i), .lim_reload_i(lim_reload_i), .lim_wdata_i(lim_wdata_i),
    .per_int_wr_i(per_int_wr_i), .per_full_wr_i(per_full_wr_i),
    .per_int_i(per_int_i), .per_frac_i(per_frac_i), .evt_clr_i(evt_clr_i),
    .count_o(count_o), .state_o(state_o), .expire_o(expire_o),
    .expire_sticky_o(expire_sticky_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model: clocks left in the current interval
  logic [1:0]  m_st;
  logic [63:0] m_cnt, m_lim;
  logic [31:0] m_p, m_f, m_acc, n_p, n_f;
  longint      m_left;
  bit          m_evt, m_sticky, b_ev, b_rs, b_run, b_tk;

  function automatic bit over(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[32];
  endfunction

  function automatic longint span(input logic [31:0] p, input logic [31:0] acc,
                                  input logic [31:0] f);
    return longint'(p) + longint'(over(acc, f));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 2'd0; m_cnt = '0; m_lim = '0; m_p = '0; m_f = '0; m_acc = '0;
      m_left = 0; m_evt = 1'b0; m_sticky = 1'b0;
    end else begin
      b_ev = 1'b0; b_rs = 1'b0;
      b_run = (m_st != 2'd0);
      b_tk  = b_run && (m_left == 1);
      n_p = (per_int_wr_i || per_full_wr_i) ? per_int_i : m_p;
      n_f = per_full_wr_i ? per_frac_i : (per_int_wr_i ? 32'd0 : m_f);
      if (stop_i && b_run) m_st = 2'd0;
      else if (start_i && !b_run) begin
        if (m_p != 0) begin
          m_st = oneshot_i ? 2'd2 : 2'd1; b_rs = 1'b1;
          if (m_cnt == 0) begin b_ev = 1'b1; m_cnt = m_lim; if (m_lim == 0) m_st = 2'd0; end
        end
      end else if (cnt_wr_i) begin
        m_cnt = cnt_wdata_i;
        if (b_run) begin
          b_rs = 1'b1;
          if (cnt_wdata_i == 0) begin b_ev = 1'b1; m_cnt = m_lim; if (m_lim == 0) m_st = 2'd0; end
        end
      end else if (lim_wr_i && lim_reload_i) begin
        m_cnt = lim_wdata_i;
        if (b_run) begin
          b_rs = 1'b1;
          if (lim_wdata_i == 0) begin b_ev = 1'b1; m_st = 2'd0; end
        end
      end else if ((per_int_wr_i || per_full_wr_i) && b_run) begin
        b_rs = 1'b1;
        if (per_int_i == 0) m_st = 2'd0;
      end else if (b_tk) begin
        b_ev = 1'b1;
        if (m_cnt > 1) begin m_cnt = m_cnt - 1; b_ev = 1'b0; end
        else if (m_st == 2'd2 || m_lim == 0) begin m_st = 2'd0; m_cnt = 0; end
        else m_cnt = m_lim;
      end
      if (lim_wr_i) m_lim = lim_wdata_i;
      m_p = n_p; m_f = n_f;
      if (b_rs) begin
        m_acc = 0; m_left = span(m_p, 0, m_f);
      end else if (b_run) begin
        if (b_tk) begin m_acc = m_acc + m_f; m_left = span(m_p, m_acc, m_f); end
        else m_left = m_left - 1;
      end
      m_sticky = b_ev ? 1'b1 : (evt_clr_i ? 1'b0 : m_sticky);
      m_evt = b_ev;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (count_o !== m_cnt || state_o !== m_st || expire_o !== m_evt ||
          expire_sticky_o !== m_sticky) begin
        fails++;
        $display("FAIL LOCKSTEP R2 R3 R9 actual cnt=%0d st=%0d ev=%0d sk=%0d expected cnt=%0d st=%0d ev=%0d sk=%0d",
                 count_o, state_o, expire_o, expire_sticky_o, m_cnt, m_st, m_evt, m_sticky);
      end
    end
  end

  // ---------------- stimulus tasks: drive after a falling edge, hold one cycle
  task automatic idle_in();
    start_i = 0; oneshot_i = 0; stop_i = 0; cnt_wr_i = 0; lim_wr_i = 0;
    lim_reload_i = 0; per_int_wr_i = 0; per_full_wr_i = 0; evt_clr_i = 0;
  endtask
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic t_start(input bit one);
    start_i = 1; oneshot_i = one; @(negedge clk); idle_in();
  endtask
  task automatic t_stop();
    stop_i = 1; @(negedge clk); idle_in();
  endtask
  task automatic t_cnt(input logic [63:0] v);
    cnt_wr_i = 1; cnt_wdata_i = v; @(negedge clk); idle_in();
  endtask
  task automatic t_lim(input logic [63:0] v, input bit rl);
    lim_wr_i = 1; lim_reload_i = rl; lim_wdata_i = v; @(negedge clk); idle_in();
  endtask
  task automatic t_pint(input logic [31:0] p);
    per_int_wr_i = 1; per_int_i = p; @(negedge clk); idle_in();
  endtask
  task automatic t_pfull(input logic [31:0] p, input logic [31:0] f);
    per_full_wr_i = 1; per_int_i = p; per_frac_i = f; @(negedge clk); idle_in();
  endtask
  task automatic t_clr();
    evt_clr_i = 1; @(negedge clk); idle_in();
  endtask
  task automatic gap(output int n);
    logic [63:0] prev;
    prev = count_o; n = 0;
    do begin @(negedge clk); n++; end while (count_o == prev && n < 50);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [63:0] frozen;
    int g;
    void'($urandom(32'd4242));
    rst_n = 0; idle_in();
    cnt_wdata_i = '0; lim_wdata_i = '0; per_int_i = '0; per_frac_i = '0;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    chk("R1 reset count", count_o, 0);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset pulse", expire_o, 0);
    chk("R1 reset sticky", expire_sticky_o, 0);

    t_start(0);
    chk("R4 start refused on zero period", state_o, 0);

    t_pint(3);
    t_cnt(2);
    t_lim(4, 0);
    chk("R8 limit write without reload keeps count", count_o, 2);
    t_start(0);
    chk("R2 running repeating", state_o, 1);
    chk("R2 count at start", count_o, 2);
    wait_n(3);
    chk("R2 first decrement", count_o, 1);
    wait_n(3);
    chk("R2 refill from limit", count_o, 4);
    chk("R2 expiry pulse", expire_o, 1);
    wait_n(1);
    chk("R11 pulse single cycle", expire_o, 0);
    chk("R11 sticky set", expire_sticky_o, 1);
    t_start(1);
    chk("R4 start while running keeps state", state_o, 1);
    chk("R4 start while running keeps count", count_o, 4);
    t_clr();
    chk("R11 sticky cleared", expire_sticky_o, 0);
    frozen = count_o;
    t_stop();
    chk("R6 stop state", state_o, 0);
    chk("R6 stop freezes count", count_o, frozen);
    wait_n(5);
    chk("R6 frozen count holds", count_o, frozen);
    t_stop();
    chk("R6 stop while stopped no effect", count_o, frozen);

    t_cnt(0);
    chk("R7 zero write while stopped no pulse", expire_o, 0);
    t_start(0);
    chk("R5 start at zero pulse", expire_o, 1);
    chk("R5 start at zero refill", count_o, 4);
    chk("R5 start at zero runs", state_o, 1);
    t_stop();

    t_cnt(1);
    t_start(1);
    chk("R3 single-run state", state_o, 2);
    wait_n(3);
    chk("R3 single-run pulse", expire_o, 1);
    chk("R3 single-run count", count_o, 0);
    chk("R3 single-run halts", state_o, 0);

    t_lim(0, 1);
    chk("R8 reload copies zero", count_o, 0);
    t_start(0);
    chk("R5 zero limit stays stopped", state_o, 0);
    chk("R5 zero limit pulse", expire_o, 1);

    t_lim(4, 1);
    t_start(0);
    wait_n(1);
    t_cnt(5);
    chk("R7 count write while running", count_o, 5);
    wait_n(2);
    chk("R7 phase restarted, no step yet", count_o, 5);
    wait_n(1);
    chk("R7 step one period after write", count_o, 4);
    t_lim(9, 0);
    chk("R8 no reload leaves count", count_o, 4);
    t_lim(7, 1);
    chk("R8 reload while running", count_o, 7);
    chk("R8 still running", state_o, 1);
    t_pint(0);
    chk("R10 zero period stops", state_o, 0);

    t_pfull(2, 32'h8000_0000);
    t_cnt(100);
    t_start(0);
    gap(g); chk("R9 interval 1", g, 2);
    gap(g); chk("R9 interval 2 stretched", g, 3);
    gap(g); chk("R9 interval 3", g, 2);
    gap(g); chk("R9 interval 4 stretched", g, 3);
    t_pint(2);
    gap(g); chk("R9 integer write clears fraction a", g, 2);
    gap(g); chk("R9 integer write clears fraction b", g, 2);
    t_stop();

    t_pint(2);
    for (int i = 0; i < 4000; i++) begin
      case ($urandom_range(0, 15))
        0: t_start($urandom_range(0, 1) == 1);
        1: t_start(0);
        2: t_stop();
        3: t_cnt(64'($urandom_range(0, 6)));
        4: t_lim(64'($urandom_range(0, 6)), $urandom_range(0, 1) == 1);
        5: t_pint($urandom_range(0, 4));
        6: t_pfull($urandom_range(1, 3), $urandom);
        7: t_clr();
        default: ;
      endcase
      wait_n(1);
    end

    finish_run();
  end

endmodule